// File: doc/BRIEF.md
# Segmented Strided Vector Memory Access Sequencer

This block turns one vector memory command into an ordered stream of requests for a memory port. A command can be strided, or unit-stride with or without a mask. Each element may carry several segment fields. Every request gives a byte address, a size in bytes, a register element index and a kind. The kind is probe, access or tail-zero.

A command runs in three phases. First a probe pass checks every address range the command will touch, splitting any range that crosses a page edge. Then the real accesses follow, field by field inside each element. A load ends with zeroing requests for the unused tail of every field. If a probe comes back faulted, the command stops before any real access and reports the faulting address. The issuing unit supplies vlmax already computed: the register group size in bytes divided by the element size.

States: IDLE waits for `start`. PROBE walks the probe pass. PROBE_HI issues the part of a probe that lies past a page edge. ACCESS walks the real accesses. ZERO walks the tail-zero requests. DONE pulses `done`. Transitions: IDLE to PROBE on start. PROBE to PROBE_HI when an accepted probe crosses a page. PROBE to ACCESS when the probe pass ends. PROBE or PROBE_HI to DONE on a faulted probe. PROBE_HI back to PROBE (strided) or on to ACCESS (single unit-stride probe). ACCESS to ZERO for a load, or to DONE for a store. ZERO to DONE after the last field. DONE to IDLE.

Top module: `seg_stride_seq`

## Requirements
- R1: After reset `req_valid`, `busy`, `done` and `fault` are all 0.
- R2: In strided mode (`cmd_mode`=1), field k of element i is accessed at base + stride·i + k·msz with size msz. Fields k = 0..nf-1 run inside each element, and elements run i = 0..vl-1.
- R3: In unit-stride mode (`cmd_mode`=0), field k of element i is accessed at base + (i·nf + k)·msz. With the mask enabled, the command behaves as a strided command with stride nf·msz.
- R4: Access requests carry `req_idx` = i + k·vlmax. Tail-zero requests carry j + k·vlmax. Probe requests carry index 0.
- R5: When `cmd_vm`=0, `mask_pos` presents i·mlen, and element i is skipped if `mask_bit` is 0. A skipped element gets neither a probe nor an access. When `cmd_vm`=1 every element is active.
- R6: All probes come before any access. Strided and masked commands probe each active element at its first field address with length nf·msz. Unmasked unit-stride issues a single probe of vl·nf·msz bytes at base, and no probe when vl=0.
- R7: A probe range that crosses a 2^PAGE_BITS page edge becomes two probes: one from its address to the end of its page, then one for the remainder. No probe request crosses a page edge.
- R8: For loads only, for every field k, tail-zero requests are issued for j = vl..vlmax-1 in ascending k then j, with address 0 and size esz. Stores issue none.
- R9: If `req_fault` is high when a probe is accepted, no further request is issued. `fault` rises with `fault_addr` equal to that probe's address, and `done` pulses. `fault` is cleared by the next start.
- R10: While `req_valid` is high and `req_ready` is low, the request stays valid and its kind, address, size and index do not change.
- R11: `done` is a single-cycle pulse after the last request of a command has been accepted, and `busy` is low in the cycle after it.
- Kind encoding: 0 probe, 1 access, 2 tail-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a command when idle |
| cmd_base | input | AW | Base byte address |
| cmd_stride | input | AW | Byte stride between elements (strided mode) |
| cmd_vl | input | VL_W | Active vector length |
| cmd_nf | input | NF_W | Fields per segment, at least 1 |
| cmd_esz | input | SZ_W | Register element size in bytes |
| cmd_msz | input | SZ_W | Memory element size in bytes |
| cmd_vlmax | input | VL_W | Elements per field register group |
| cmd_vm | input | 1 | 1: unmasked, 0: use mask |
| cmd_mlen | input | ML_W | Mask bit spacing per element |
| cmd_load | input | 1 | 1 load, 0 store |
| cmd_mode | input | 1 | 0 unit-stride, 1 strided |
| mask_pos | output | VL_W+ML_W | Mask bit position i·mlen being looked up |
| mask_bit | input | 1 | Mask bit at `mask_pos` |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted when high with valid |
| req_kind | output | 2 | 0 probe, 1 access, 2 tail-zero |
| req_addr | output | AW | Byte address |
| req_size | output | AW | Size in bytes |
| req_idx | output | VL_W+NF_W | Register element index |
| req_fault | input | 1 | Probe fault, sampled with probe handshake |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end of command |
| fault | output | 1 | Last command stopped on a probe fault |
| fault_addr | output | AW | Address of the faulting probe |

## Verification
On every cycle the assertions check four things. A stalled request does not change. No probe crosses a page edge. No request follows a fault, and tail-zero requests appear only for loads. Every index stays inside the nf·vlmax register span, and done is a lone pulse followed by idle. The exact sequence of addresses, sizes and indices can only be shown by the bench scenarios, which compare against an independently built expected list. The same holds for mask skipping, probe ordering, the split lengths and the fault cut-off point.

// File: rtl/seg_seq_pkg.sv
package seg_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_PROBE_HI,
        ST_ACCESS,
        ST_ZERO,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] KIND_PROBE  = 2'd0;
    localparam logic [1:0] KIND_ACCESS = 2'd1;
    localparam logic [1:0] KIND_ZERO   = 2'd2;

    localparam logic MODE_UNIT    = 1'b0;
    localparam logic MODE_STRIDED = 1'b1;
endpackage

// File: rtl/seg_page_split.sv
module seg_page_split #(
    parameter int AW         = 32,
    parameter int PAGE_BITS  = 12
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] len,
    output logic          crosses,
    output logic [AW-1:0] first_len,
    output logic [AW-1:0] rest_addr,
    output logic [AW-1:0] rest_len
);
    localparam logic [AW-1:0] PAGE_SIZE = AW'(1) << PAGE_BITS;

    logic [AW-1:0] room;

    always_comb begin
        room      = PAGE_SIZE - AW'(addr[PAGE_BITS-1:0]);
        crosses   = len > room;
        first_len = crosses ? room : len;
        rest_addr = addr + room;
        rest_len  = len - room;
    end
endmodule

// File: rtl/seg_mask_tap.sv
module seg_mask_tap #(
    parameter int MP_W = 15,
    parameter int ML_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    input  logic [ML_W-1:0] step,
    output logic [MP_W-1:0] pos
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (clr) begin
            pos <= '0;
        end else if (adv) begin
            pos <= pos + MP_W'(step);
        end
    end
endmodule

// File: rtl/seg_stride_seq.sv
module seg_stride_seq
    import seg_seq_pkg::*;
#(
    parameter int AW        = 32,
    parameter int VL_W      = 8,
    parameter int NF_W      = 4,
    parameter int SZ_W      = 4,
    parameter int ML_W      = 7,
    parameter int PAGE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        cmd_base,
    input  logic [AW-1:0]        cmd_stride,
    input  logic [VL_W-1:0]      cmd_vl,
    input  logic [NF_W-1:0]      cmd_nf,
    input  logic [SZ_W-1:0]      cmd_esz,
    input  logic [SZ_W-1:0]      cmd_msz,
    input  logic [VL_W-1:0]      cmd_vlmax,
    input  logic                 cmd_vm,
    input  logic [ML_W-1:0]      cmd_mlen,
    input  logic                 cmd_load,
    input  logic                 cmd_mode,
    output logic [VL_W+ML_W-1:0] mask_pos,
    input  logic                 mask_bit,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [1:0]           req_kind,
    output logic [AW-1:0]        req_addr,
    output logic [AW-1:0]        req_size,
    output logic [VL_W+NF_W-1:0] req_idx,
    input  logic                 req_fault,
    output logic                 busy,
    output logic                 done,
    output logic                 fault,
    output logic [AW-1:0]        fault_addr
);
    localparam int IDX_W = VL_W + NF_W;
    localparam int MP_W  = VL_W + ML_W;
    localparam int GRP_W = NF_W + SZ_W;
    localparam logic [AW:0] PAGE_SPAN = (AW+1)'(1) << PAGE_BITS;

    seq_state_e state, nxt_state;

    // latched command
    logic [AW-1:0]    base_r, stride_r;
    logic [VL_W-1:0]  vl_r, vlmax_r;
    logic [NF_W-1:0]  nf_r;
    logic [SZ_W-1:0]  esz_r, msz_r;
    logic [ML_W-1:0]  mlen_r;
    logic             vm_r, ld_r, us_r;
    // walk state
    logic [VL_W-1:0]  i_r, j_r;
    logic [NF_W-1:0]  k_r;
    logic [AW-1:0]    elem_addr, fld_addr;
    logic [IDX_W-1:0] kb_r;
    logic             fault_r;
    logic [AW-1:0]    fault_addr_r;

    // control strobes
    logic do_load, do_walk_init, do_adv_elem, do_adv_field;
    logic do_zero_init, do_zfield, do_zstep, do_fault;

    logic             active, fire, last_field;
    logic [GRP_W-1:0] grp_bytes;
    logic [AW-1:0]    probe_len, first_len, rest_addr, rest_len;
    logic             crosses;

    assign active     = vm_r | mask_bit;
    assign fire       = req_valid & req_ready;
    assign last_field = (k_r == nf_r - NF_W'(1));
    assign grp_bytes  = GRP_W'(nf_r) * GRP_W'(msz_r);
    assign probe_len  = us_r ? AW'(vl_r) * AW'(grp_bytes) : AW'(grp_bytes);

    seg_page_split #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_split (
        .addr      (elem_addr),
        .len       (probe_len),
        .crosses   (crosses),
        .first_len (first_len),
        .rest_addr (rest_addr),
        .rest_len  (rest_len)
    );

    seg_mask_tap #(.MP_W(MP_W), .ML_W(ML_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (do_load | do_walk_init),
        .adv   (do_adv_elem),
        .step  (mlen_r),
        .pos   (mask_pos)
    );

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            base_r       <= '0;
            stride_r     <= '0;
            vl_r         <= '0;
            vlmax_r      <= '0;
            nf_r         <= '0;
            esz_r        <= '0;
            msz_r        <= '0;
            mlen_r       <= '0;
            vm_r         <= 1'b0;
            ld_r         <= 1'b0;
            us_r         <= 1'b0;
            i_r          <= '0;
            j_r          <= '0;
            k_r          <= '0;
            elem_addr    <= '0;
            fld_addr     <= '0;
            kb_r         <= '0;
            fault_r      <= 1'b0;
            fault_addr_r <= '0;
        end else begin
            state <= nxt_state;
            if (do_load) begin
                base_r    <= cmd_base;
                stride_r  <= (cmd_mode == MODE_UNIT) ? AW'(GRP_W'(cmd_nf) * GRP_W'(cmd_msz)) : cmd_stride;
                vl_r      <= cmd_vl;
                vlmax_r   <= cmd_vlmax;
                nf_r      <= cmd_nf;
                esz_r     <= cmd_esz;
                msz_r     <= cmd_msz;
                mlen_r    <= cmd_mlen;
                vm_r      <= cmd_vm;
                ld_r      <= cmd_load;
                us_r      <= (cmd_mode == MODE_UNIT) && cmd_vm;
                i_r       <= '0;
                k_r       <= '0;
                elem_addr <= cmd_base;
                fld_addr  <= cmd_base;
                kb_r      <= '0;
                fault_r   <= 1'b0;
            end
            if (do_walk_init) begin
                i_r       <= '0;
                k_r       <= '0;
                elem_addr <= base_r;
                fld_addr  <= base_r;
                kb_r      <= '0;
            end
            if (do_adv_elem) begin
                i_r       <= i_r + VL_W'(1);
                k_r       <= '0;
                elem_addr <= elem_addr + stride_r;
                fld_addr  <= elem_addr + stride_r;
                kb_r      <= '0;
            end
            if (do_adv_field) begin
                k_r      <= k_r + NF_W'(1);
                fld_addr <= fld_addr + AW'(msz_r);
                kb_r     <= kb_r + IDX_W'(vlmax_r);
            end
            if (do_zero_init) begin
                k_r  <= '0;
                j_r  <= vl_r;
                kb_r <= '0;
            end
            if (do_zfield) begin
                k_r  <= k_r + NF_W'(1);
                j_r  <= vl_r;
                kb_r <= kb_r + IDX_W'(vlmax_r);
            end
            if (do_zstep) begin
                j_r <= j_r + VL_W'(1);
            end
            if (do_fault) begin
                fault_r      <= 1'b1;
                fault_addr_r <= req_addr;
            end
        end
    end

    // request outputs
    always_comb begin
        req_valid = 1'b0;
        req_kind  = KIND_PROBE;
        req_addr  = '0;
        req_size  = '0;
        req_idx   = '0;
        unique case (state)
            ST_PROBE: begin
                if (us_r ? (vl_r != '0) : ((i_r != vl_r) && active)) begin
                    req_valid = 1'b1;
                    req_addr  = elem_addr;
                    req_size  = first_len;
                end
            end
            ST_PROBE_HI: begin
                req_valid = 1'b1;
                req_addr  = rest_addr;
                req_size  = rest_len;
            end
            ST_ACCESS: begin
                if ((i_r != vl_r) && active) begin
                    req_valid = 1'b1;
                    req_kind  = KIND_ACCESS;
                    req_addr  = fld_addr;
                    req_size  = AW'(msz_r);
                    req_idx   = kb_r + IDX_W'(i_r);
                end
            end
            ST_ZERO: begin
                if (j_r < vlmax_r) begin
                    req_valid = 1'b1;
                    req_kind  = KIND_ZERO;
                    req_size  = AW'(esz_r);
                    req_idx   = kb_r + IDX_W'(j_r);
                end
            end
            default: ;
        endcase
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
        fault      = fault_r;
        fault_addr = fault_addr_r;
    end

    // next state and walk control
    always_comb begin
        nxt_state    = state;
        do_load      = 1'b0;
        do_walk_init = 1'b0;
        do_adv_elem  = 1'b0;
        do_adv_field = 1'b0;
        do_zero_init = 1'b0;
        do_zfield    = 1'b0;
        do_zstep     = 1'b0;
        do_fault     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    do_load   = 1'b1;
                    nxt_state = ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (us_r ? (vl_r == '0) : (i_r == vl_r)) begin
                    do_walk_init = 1'b1;
                    nxt_state    = ST_ACCESS;
                end else if (!us_r && !active) begin
                    do_adv_elem = 1'b1;
                end else if (fire) begin
                    if (req_fault) begin
                        do_fault  = 1'b1;
                        nxt_state = ST_DONE;
                    end else if (crosses) begin
                        nxt_state = ST_PROBE_HI;
                    end else if (us_r) begin
                        do_walk_init = 1'b1;
                        nxt_state    = ST_ACCESS;
                    end else begin
                        do_adv_elem = 1'b1;
                    end
                end
            end
            ST_PROBE_HI: begin
                if (fire) begin
                    if (req_fault) begin
                        do_fault  = 1'b1;
                        nxt_state = ST_DONE;
                    end else if (us_r) begin
                        do_walk_init = 1'b1;
                        nxt_state    = ST_ACCESS;
                    end else begin
                        do_adv_elem = 1'b1;
                        nxt_state   = ST_PROBE;
                    end
                end
            end
            ST_ACCESS: begin
                if (i_r == vl_r) begin
                    if (ld_r) begin
                        do_zero_init = 1'b1;
                        nxt_state    = ST_ZERO;
                    end else begin
                        nxt_state = ST_DONE;
                    end
                end else if (!active) begin
                    do_adv_elem = 1'b1;
                end else if (fire) begin
                    if (last_field) do_adv_elem = 1'b1;
                    else            do_adv_field = 1'b1;
                end
            end
            ST_ZERO: begin
                if (j_r >= vlmax_r) begin
                    if (last_field) nxt_state = ST_DONE;
                    else            do_zfield = 1'b1;
                end else if (fire) begin
                    do_zstep = 1'b1;
                end
            end
            ST_DONE: nxt_state = ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    // R10: a stalled request is held unchanged
    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_kind) && $stable(req_addr)
                                       && $stable(req_size) && $stable(req_idx)));

    // R7: no probe request spans a page edge
    assert_probe_in_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_PROBE) |->
            ((AW+1)'(req_addr[PAGE_BITS-1:0]) + (AW+1)'(req_size) <= PAGE_SPAN));

    // R9: nothing is requested once a probe has faulted
    assert_quiet_after_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !req_valid);

    // R8: tail zeroing belongs to loads only
    assert_zero_only_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_ZERO) |-> ld_r);

    // R4: register index stays inside the nf*vlmax span
    assert_idx_in_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != KIND_PROBE) |->
            ((IDX_W+1)'(req_idx) < (IDX_W+1)'(nf_r) * (IDX_W+1)'(vlmax_r)));

    // R11: done is a lone pulse followed by idle
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: tb/seg_stride_seq_tb.sv
`timescale 1ns/1ps
module seg_stride_seq_tb;
    import seg_seq_pkg::*;

    localparam int AW = 32, VL_W = 8, NF_W = 4, SZ_W = 4, ML_W = 7, PAGE_BITS = 12;
    localparam int EXP_MAX = 1024;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, start, cmd_vm, cmd_load, cmd_mode, mask_bit, req_valid, req_ready;
    logic req_fault, busy, done, fault;
    logic [AW-1:0] cmd_base, cmd_stride, req_addr, req_size, fault_addr;
    logic [VL_W-1:0] cmd_vl, cmd_vlmax;
    logic [NF_W-1:0] cmd_nf;
    logic [SZ_W-1:0] cmd_esz, cmd_msz;
    logic [ML_W-1:0] cmd_mlen;
    logic [VL_W+ML_W-1:0] mask_pos;
    logic [1:0] req_kind;
    logic [VL_W+NF_W-1:0] req_idx;

    logic mask_mem [0:255];
    assign mask_bit = mask_mem[mask_pos[7:0]];

    seg_stride_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
        .cmd_vl(cmd_vl), .cmd_nf(cmd_nf), .cmd_esz(cmd_esz), .cmd_msz(cmd_msz),
        .cmd_vlmax(cmd_vlmax), .cmd_vm(cmd_vm), .cmd_mlen(cmd_mlen), .cmd_load(cmd_load),
        .cmd_mode(cmd_mode), .mask_pos(mask_pos), .mask_bit(mask_bit), .req_valid(req_valid),
        .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr), .req_size(req_size),
        .req_idx(req_idx), .req_fault(req_fault), .busy(busy), .done(done), .fault(fault),
        .fault_addr(fault_addr)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    logic [1:0]  e_kind [0:EXP_MAX-1];
    logic [31:0] e_addr [0:EXP_MAX-1];
    logic [31:0] e_size [0:EXP_MAX-1];
    logic [11:0] e_idx  [0:EXP_MAX-1];
    int exp_n, pcount, fault_tgt;
    bit stop_exp, e_fault;
    logic [31:0] e_faddr;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic add_req(input logic [1:0] k, input logic [31:0] a, input logic [31:0] s, input int idx);
        if (!stop_exp && exp_n < EXP_MAX) begin
            e_kind[exp_n] = k; e_addr[exp_n] = a; e_size[exp_n] = s; e_idx[exp_n] = 12'(idx);
            exp_n++;
            if (k == KIND_PROBE) begin
                if (pcount == fault_tgt) begin
                    stop_exp = 1; e_fault = 1; e_faddr = a;
                end
                pcount++;
            end
        end
    endtask

    task automatic add_probe(input logic [31:0] a, input logic [31:0] len);
        logic [31:0] room = 32'd4096 - {20'd0, a[11:0]};
        if (len > room) begin
            add_req(KIND_PROBE, a, room, 0);
            add_req(KIND_PROBE, a + room, len - room, 0);
        end else begin
            add_req(KIND_PROBE, a, len, 0);
        end
    endtask

    function automatic bit is_act(input bit vm, input int mlen, input int i);
        return vm || mask_mem[(i * mlen) % 256];
    endfunction

    task automatic build(input logic [31:0] base, input logic [31:0] stride, input int vl, input int nf,
                         input int esz, input int msz, input int vlmax, input bit vm, input int mlen,
                         input bit ld, input bit mode);
        logic [31:0] s;
        exp_n = 0; stop_exp = 0; pcount = 0; e_fault = 0; e_faddr = 0;
        s = (mode == MODE_UNIT) ? 32'(nf * msz) : stride;
        if (mode == MODE_UNIT && vm) begin
            if (vl > 0) add_probe(base, 32'(vl * nf * msz));
        end else begin
            for (int i = 0; i < vl; i++)
                if (is_act(vm, mlen, i)) add_probe(base + s * 32'(i), 32'(nf * msz));
        end
        for (int i = 0; i < vl; i++)
            if (is_act(vm, mlen, i))
                for (int k = 0; k < nf; k++)
                    add_req(KIND_ACCESS, base + s * 32'(i) + 32'(k * msz), 32'(msz), i + k * vlmax);
        if (ld)
            for (int k = 0; k < nf; k++)
                for (int j = vl; j < vlmax; j++)
                    add_req(KIND_ZERO, 32'd0, 32'(esz), j + k * vlmax);
    endtask

    task automatic run_op(input string tag, input logic [31:0] base, input logic [31:0] stride,
                          input int vl, input int nf, input int esz, input int msz, input int vlmax,
                          input bit vm, input int mlen, input bit ld, input bit mode, input int ftgt);
        int ptr = 0, probe_seen = 0;
        bit stall = 0, finished = 0;
        logic [63:0] held, cur;
        fault_tgt = ftgt;
        build(base, stride, vl, nf, esz, msz, vlmax, vm, mlen, ld, mode);
        @(negedge clk);
        start = 1; cmd_base = base; cmd_stride = stride; cmd_vl = VL_W'(vl); cmd_nf = NF_W'(nf);
        cmd_esz = SZ_W'(esz); cmd_msz = SZ_W'(msz); cmd_vlmax = VL_W'(vlmax); cmd_vm = vm;
        cmd_mlen = ML_W'(mlen); cmd_load = ld; cmd_mode = mode;
        held = '0;
        for (int c = 0; c < 20000 && !finished; c++) begin
            @(negedge clk);
            start = 0; req_fault = 0;
            cur = {req_kind, req_addr, req_size[17:0], req_idx};
            if (stall) chk(req_valid && cur == held, "R10", "stalled request changed", cur, held);
            if (done) begin
                req_ready = 0;
                chk(ptr == exp_n, tag, "R11 request count at done", 64'(ptr), 64'(exp_n));
                chk(fault == e_fault, tag, "R9 fault flag", 64'(fault), 64'(e_fault));
                if (e_fault) chk(fault_addr == e_faddr, tag, "R9 fault address", 64'(fault_addr), 64'(e_faddr));
                finished = 1;
            end else begin
                req_ready = ($urandom % 4) != 0;
                if (req_valid && req_ready) begin
                    if (ptr >= exp_n) begin
                        chk(0, tag, "unexpected extra request", cur, 64'(0));
                    end else begin
                        chk(cur == {e_kind[ptr], e_addr[ptr], e_size[ptr][17:0], e_idx[ptr]},
                            tag, "request kind/addr/size/idx", cur,
                            {e_kind[ptr], e_addr[ptr], e_size[ptr][17:0], e_idx[ptr]});
                    end
                    if (req_kind == KIND_PROBE) begin
                        if (probe_seen == fault_tgt) req_fault = 1;
                        probe_seen++;
                    end
                    ptr++;
                end
                stall = req_valid && !req_ready;
                held = cur;
            end
        end
        if (!finished) chk(0, tag, "R11 command never finished", 64'(0), 64'(1));
        @(negedge clk);
        chk(!done && !busy, tag, "R11 done pulse then idle", {62'd0, done, busy}, 64'(0));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; start = 0; req_ready = 0; req_fault = 0;
        cmd_base = '0; cmd_stride = '0; cmd_vl = '0; cmd_nf = '0; cmd_esz = '0; cmd_msz = '0;
        cmd_vlmax = '0; cmd_vm = 0; cmd_mlen = '0; cmd_load = 0; cmd_mode = 0;
        for (int m = 0; m < 256; m++) mask_mem[m] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!req_valid && !busy && !done && !fault, "R1", "reset outputs",
            {60'd0, req_valid, busy, done, fault}, 64'(0));

        // R2 R4 R8: strided load, two fields, tail zeroing
        run_op("R2 R4 R8", 32'h1000, 32'h40, 5, 2, 4, 4, 8, 1, 1, 1, MODE_STRIDED, -1);
        // R3 R7: unit-stride unmasked load, single probe split at the page edge, no tail
        run_op("R3 R7", 32'h1FF0, 32'h0, 6, 1, 4, 4, 6, 1, 1, 1, MODE_UNIT, -1);
        // R3 R5: masked unit-stride store, even elements active (bit 2i set when i even)
        for (int m = 0; m < 256; m++) mask_mem[m] = (m % 4) == 0;
        run_op("R3 R5", 32'h3000, 32'h0, 8, 2, 2, 2, 8, 0, 2, 0, MODE_UNIT, -1);
        // R5: masked strided load, mlen 1
        run_op("R5", 32'h8000, 32'h20, 7, 3, 1, 1, 9, 0, 1, 1, MODE_STRIDED, -1);
        for (int m = 0; m < 256; m++) mask_mem[m] = 1'b1;
        // R7 R2: negative stride, second element probe crosses the page
        run_op("R7 R2", 32'h5002, 32'hFFFF_FFFC, 4, 3, 2, 2, 4, 1, 1, 0, MODE_STRIDED, -1);
        // R9: second probe faults, no access follows
        run_op("R9", 32'h2000, 32'h100, 4, 2, 8, 8, 4, 1, 1, 1, MODE_STRIDED, 1);
        // R9: unit-stride probe faults on the upper half of a split
        run_op("R9 R7", 32'h6FFC, 32'h0, 4, 2, 2, 2, 4, 1, 1, 1, MODE_UNIT, 1);
        // R6 R8: vl of zero on unit-stride, no probe, only tail zeroing
        run_op("R6 R8", 32'h7000, 32'h0, 0, 2, 2, 2, 3, 1, 1, 1, MODE_UNIT, -1);
        // R6 R8: strided store, probes first, no tail zeroing
        run_op("R6 R8", 32'h9000, 32'h30, 3, 2, 4, 4, 8, 1, 1, 0, MODE_STRIDED, -1);

        // constrained random commands
        for (int r = 0; r < 40; r++) begin
            int vl = $urandom % 13;
            int vlmax = vl + ($urandom % 5);
            int msz = 1 << ($urandom % 4);
            int esz = msz << ($urandom % 2);
            int nf = 1 + ($urandom % 8);
            int mlen = 1 << ($urandom % 4);
            bit vm = $urandom % 2;
            bit mode = $urandom % 2;
            bit ld = $urandom % 2;
            int ftgt = (($urandom % 4) == 0) ? int'($urandom % 3) : -1;
            logic [31:0] base = $urandom;
            logic [31:0] stride = (($urandom % 2) == 0) ? 32'(($urandom % 512)) : -32'(($urandom % 512));
            if (esz > 8) esz = 8;
            if (vlmax == 0) vlmax = 1;
            for (int m = 0; m < 256; m++) mask_mem[m] = $urandom % 2;
            run_op("rand R2 R3 R4 R5 R6 R7 R8 R9", base, stride, vl, nf, esz, msz, vlmax,
                   vm, mlen, ld, mode, ftgt);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule